// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block keeps the global interrupt enable of a small CPU core and its halted state. The instruction decoder sends it one-cycle pulses for the disable, enable, return-from-interrupt and halt instructions. Each pulse arrives in the last cycle of its instruction, together with the instruction-boundary strobe. The block also watches the per-line interrupt enable and interrupt flag vectors and combines them into a single pending condition.

From these inputs it drives four outputs. The first is the master enable. The second is a halted flag that stalls the fetch unit. The third is a dispatch request, which the vector logic takes to start a handler. The fourth is a one-cycle hold that stops the program counter from advancing once. That hold reproduces the duplicated fetch that follows a halt issued while interrupts are masked but one is already pending. The enable instruction acts late: the master enable rises only after the instruction that follows it has finished.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While reset is held and after it is released, `ime`, `halted`, `pc_hold` and `irq_req` are all 0, and no delayed enable is armed.
- R2: A `di_pulse` makes `ime` 0 from the next cycle.
- R3: An `ei_pulse` leaves `ime` at 0 through the next `instr_done` cycle. `ime` reads 1 from the cycle after that following boundary.
- R4: A `di_pulse` that arrives after an `ei_pulse` but before the following boundary cancels the delayed enable, so `ime` stays 0.
- R5: A `reti_pulse` makes `ime` 1 from the next cycle, with no extra delay.
- R6: An interrupt is pending when any bit position i has both `irq_enable[i]` and `irq_flag[i]` set. Bit i of each vector belongs to interrupt line i.
- R7: `irq_req` is 1 in a cycle exactly when `ime` is 1, an interrupt is pending, and either `instr_done` or `halted` is 1.
- R8: A cycle with `irq_req` high makes `ime` 0 from the next cycle, and it cancels any armed delayed enable.
- R9: A `halt_pulse` sets `halted` from the next cycle when `ime` is 1 or nothing is pending. The exception is a cycle in which `irq_req` is high, where `halted` stays 0.
- R10: While `halted` is 1, a pending interrupt makes `halted` 0 in the next cycle, whatever the value of `ime`. When `ime` is 1, `irq_req` is high in that detection cycle.
- R11: A `halt_pulse` with `ime` 0 and an interrupt pending leaves `halted` at 0. It raises `pc_hold` for exactly the one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| di_pulse | input | 1 | Disable-interrupts instruction completes this cycle |
| ei_pulse | input | 1 | Enable-interrupts instruction completes this cycle |
| reti_pulse | input | 1 | Return-from-interrupt completes this cycle |
| halt_pulse | input | 1 | Halt instruction completes this cycle |
| instr_done | input | 1 | Instruction boundary strobe |
| irq_enable | input | NUM_LINES | Per-line interrupt enable |
| irq_flag | input | NUM_LINES | Per-line interrupt request flag |
| ime | output | 1 | Interrupt master enable |
| halted | output | 1 | Core is halted |
| irq_req | output | 1 | Start handler dispatch this cycle |
| pc_hold | output | 1 | Suppress the next program counter increment |

## Verification
The pending and request logic is driven by a table of enable and flag pairs. The pairs include a single matching line at the lowest and highest positions, a flag raised on a line that is not enabled, all lines enabled with no flag, and overlaps in the middle. Together these separate a true per-line AND from an OR, and from a compare of the whole vectors. Directed sequences then cover the rest. They place the enable instruction in front of idle and boundary cycles to tell the one-instruction delay from an immediate set. They cancel that delay with a disable. They also run all three halt exits: masked and idle, unmasked with dispatch, and masked with a flag already pending. These exits tell apart the wake-up path, the dispatch path and the program counter hold.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_LINES_DEF = 5;

  // decoded control pulses, one per instruction kind
  typedef struct packed {
    logic di;
    logic ei;
    logic reti;
    logic halt;
  } irqc_op_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned NUM_LINES = 5
) (
  input  logic [NUM_LINES-1:0] line_en,
  input  logic [NUM_LINES-1:0] line_flag,
  output logic                 any_pending
);
  logic [NUM_LINES-1:0] hit;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign hit[g] = line_en[g] & line_flag[g];
  end

  assign any_pending = |hit;
endmodule

// File: rtl/irqc_ime.sv
module irqc_ime
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irqc_op_t op,
  input  logic     boundary,
  input  logic     pending,
  input  logic     halted,
  output logic     ime,
  output logic     irq_req
);
  logic ime_q, ime_d, ime_en;
  logic arm_q, arm_d, arm_en;
  logic fire;

  // dispatch request: unmasked pending seen at a boundary or while halted
  assign irq_req = ime_q & pending & (boundary | halted);
  // armed enable takes effect at the next boundary after the enable itself
  assign fire    = arm_q & boundary;

  always_comb begin
    ime_d = ime_q;
    if (fire)    ime_d = 1'b1;
    if (op.reti) ime_d = 1'b1;
    if (op.di)   ime_d = 1'b0;
    if (irq_req) ime_d = 1'b0;
    ime_en = fire | op.reti | op.di | irq_req;
  end

  always_comb begin
    arm_d = arm_q;
    if (fire)              arm_d = 1'b0;
    if (op.ei)             arm_d = 1'b1;
    if (op.di || irq_req)  arm_d = 1'b0;
    arm_en = fire | op.ei | op.di | irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (ime_en) ime_q <= ime_d;
      if (arm_en) arm_q <= arm_d;
    end
  end

  assign ime = ime_q;

  p_di_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op.di |=> !ime_q);
  p_ei_delayed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op.ei && !arm_q && !ime_q && !op.reti) |=> !ime_q);
  p_di_cancels_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op.di |=> !arm_q);
  p_reti_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op.reti && !op.di && !irq_req) |=> ime_q);
  p_req_clears_ime_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (!ime_q && !arm_q));
endmodule

// File: rtl/irqc_halt.sv
module irqc_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_op,
  input  logic ime,
  input  logic pending,
  input  logic irq_req,
  output logic halted,
  output logic pc_hold
);
  logic halted_q, halted_d, halted_en;
  logic hold_q, hold_d;
  logic bug_case;

  assign bug_case = halt_op & ~ime & pending;

  always_comb begin
    halted_d  = halted_q;
    halted_en = 1'b0;
    if (halted_q) begin
      halted_en = pending;
      halted_d  = 1'b0;
    end else if (halt_op && !bug_case && !irq_req) begin
      halted_en = 1'b1;
      halted_d  = 1'b1;
    end
  end

  assign hold_d = bug_case;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (halted_en) halted_q <= halted_d;
      hold_q <= hold_d;
    end
  end

  assign halted  = halted_q;
  assign pc_hold = hold_q;

  p_halt_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_op && !halted_q && (ime || !pending) && !irq_req) |=> halted_q);
  p_halt_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && pending) |=> !halted_q);
  p_bug_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_op && !ime && pending && !halted_q) |=> (pc_hold && !halted_q));
  p_hold_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |=> !pc_hold);
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQC_LINES_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 di_pulse,
  input  logic                 ei_pulse,
  input  logic                 reti_pulse,
  input  logic                 halt_pulse,
  input  logic                 instr_done,
  input  logic [NUM_LINES-1:0] irq_enable,
  input  logic [NUM_LINES-1:0] irq_flag,
  output logic                 ime,
  output logic                 halted,
  output logic                 irq_req,
  output logic                 pc_hold
);
  localparam int unsigned SYNC_STAGES = 2;

  logic     rst_n_s;
  logic     pending;
  irqc_op_t op;

  assign op = '{di: di_pulse, ei: ei_pulse, reti: reti_pulse, halt: halt_pulse};

  irqc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irqc_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .line_en     (irq_enable),
    .line_flag   (irq_flag),
    .any_pending (pending)
  );

  irqc_ime u_ime (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .op       (op),
    .boundary (instr_done),
    .pending  (pending),
    .halted   (halted),
    .ime      (ime),
    .irq_req  (irq_req)
  );

  irqc_halt u_halt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .halt_op (op.halt),
    .ime     (ime),
    .pending (pending),
    .irq_req (irq_req),
    .halted  (halted),
    .pc_hold (pc_hold)
  );

  p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (ime && (instr_done || halted) && ((irq_enable & irq_flag) != '0)));
endmodule

// File: tb/test_irq_halt_ctrl.sv
`timescale 1ns/1ps
module test_irq_halt_ctrl;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic di_pulse, ei_pulse, reti_pulse, halt_pulse, instr_done;
  logic [N-1:0] irq_enable, irq_flag;
  logic ime, halted, irq_req, pc_hold;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_halt_ctrl #(.NUM_LINES(N)) i_irq_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .di_pulse(di_pulse), .ei_pulse(ei_pulse),
    .reti_pulse(reti_pulse), .halt_pulse(halt_pulse), .instr_done(instr_done),
    .irq_enable(irq_enable), .irq_flag(irq_flag),
    .ime(ime), .halted(halted), .irq_req(irq_req), .pc_hold(pc_hold)
  );

  // {enable, flag, expected request with ime=1 at a boundary}
  localparam logic [2*N:0] VEC [8] = '{
    {5'b00001, 5'b00001, 1'b1},
    {5'b00010, 5'b00001, 1'b0},
    {5'b10000, 5'b10000, 1'b1},
    {5'b11111, 5'b00000, 1'b0},
    {5'b00000, 5'b11111, 1'b0},
    {5'b01010, 5'b00110, 1'b1},
    {5'b10101, 5'b01010, 1'b0},
    {5'b00100, 5'b11111, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_ops();
    di_pulse = 0; ei_pulse = 0; reti_pulse = 0; halt_pulse = 0; instr_done = 0;
  endtask

  task automatic do_reti();
    reti_pulse = 1; instr_done = 1; tick(); clear_ops();
  endtask

  task automatic do_di();
    di_pulse = 1; instr_done = 1; tick(); clear_ops();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_ops();
    irq_enable = '0; irq_flag = '0;
    rst_n = 0;
    #1;
    check("R1 ime in reset", ime, 0);
    check("R1 halted in reset", halted, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    check("R1 ime after reset", ime, 0);
    check("R1 halted after reset", halted, 0);
    check("R1 pc_hold after reset", pc_hold, 0);
    check("R1 irq_req after reset", irq_req, 0);

    // R7 / R6 table: arm ime with reti, then present a boundary
    for (int k = 0; k < 8; k++) begin
      do_reti();
      check("R5 reti sets ime", ime, 1);
      irq_enable = VEC[k][2*N:N+1];
      irq_flag   = VEC[k][N:1];
      instr_done = 1;
      #1;
      check("R7 R6 request from table", irq_req, VEC[k][0]);
      tick();
      clear_ops();
      check("R8 ime after table step", ime, !VEC[k][0]);
      irq_enable = '0; irq_flag = '0;
      do_di();
    end

    // R7: no request off-boundary and not halted
    do_reti();
    irq_enable = 5'b00001; irq_flag = 5'b00001;
    #1;
    check("R7 no request between boundaries", irq_req, 0);
    instr_done = 1; #1;
    check("R7 request at boundary", irq_req, 1);
    tick(); clear_ops();
    check("R8 dispatch clears ime", ime, 0);
    irq_enable = '0; irq_flag = '0;

    // R2
    do_reti();
    do_di();
    check("R2 di clears ime", ime, 0);

    // R3: enable delayed by one instruction
    ei_pulse = 1; instr_done = 1; tick(); clear_ops();
    check("R3 ime after ei boundary", ime, 0);
    tick();
    check("R3 ime during next instruction", ime, 0);
    instr_done = 1; tick(); clear_ops();
    check("R3 ime after following boundary", ime, 1);
    do_di();

    // R4: di cancels armed enable
    ei_pulse = 1; instr_done = 1; tick(); clear_ops();
    do_di();
    instr_done = 1; tick(); clear_ops();
    tick();
    check("R4 cancelled enable stays off", ime, 0);

    // R9 / R10: masked halt, nothing pending, wake without dispatch
    halt_pulse = 1; instr_done = 1; tick(); clear_ops();
    check("R9 halted after masked halt", halted, 1);
    irq_enable = 5'b01000; irq_flag = 5'b00100;
    repeat (3) tick();
    check("R9 stays halted on unenabled flag", halted, 1);
    irq_flag = 5'b01000; #1;
    check("R10 no dispatch when masked", irq_req, 0);
    tick();
    check("R10 wake without ime", halted, 0);
    check("R10 ime still clear", ime, 0);
    irq_enable = '0; irq_flag = '0;

    // R9 / R10: unmasked halt with dispatch
    do_reti();
    halt_pulse = 1; instr_done = 1; tick(); clear_ops();
    check("R9 halted with ime set", halted, 1);
    irq_enable = 5'b10000; irq_flag = 5'b10000; #1;
    check("R10 dispatch while halted", irq_req, 1);
    tick();
    check("R10 wake with ime", halted, 0);
    check("R8 ime cleared by dispatch", ime, 0);
    irq_enable = '0; irq_flag = '0;

    // R11: masked halt with pending interrupt
    irq_enable = 5'b00010; irq_flag = 5'b00010;
    halt_pulse = 1; instr_done = 1; tick(); clear_ops();
    check("R11 no halt on bug path", halted, 0);
    check("R11 pc_hold raised", pc_hold, 1);
    tick();
    check("R11 pc_hold one cycle", pc_hold, 0);
    check("R11 still running", halted, 0);
    irq_enable = '0; irq_flag = '0;

    // R1: reset mid-run returns to idle
    do_reti();
    rst_n = 0; #1;
    check("R1 ime cleared by async reset", ime, 0);
    tick(); rst_n = 1; repeat (3) tick();
    check("R1 ime after second reset", ime, 0);

    finish_run();
  end
endmodule